// File: doc/BRIEF.md
# Serial NOR Flash Sector Erase Sequencer

This block erases one sector of a serial NOR flash on its own. A single start pulse and an address begin the sequence. The engine then sends three kinds of command, each in its own chip-select frame. First it sets the write-enable latch. Next it sends the sector-erase command with a 24-bit offset. Finally it reads the flash status byte again and again until the write-in-progress flag clears. If a cycle budget runs out first, it gives up and reports a timeout instead.

The block does not shift bits itself. It drives a byte-level SPI master. The sequencer holds a byte request until the master acknowledges it. With the acknowledge, the master returns the byte it received in the same exchange. Chip select is the sequencer's own output, and it frames each command. Each erase sends exactly one write-enable, one erase frame and one or more status polls. Between frames, chip select stays low for a fixed number of cycles.

Top module: `spi_flash_sector_eraser`

## Requirements
- R1: After reset, busy, done, timeout, chip select and byte request are all low.
- R2: A start pulse while idle sets busy on the next cycle. Only bits 23:0 of the 32-bit address are used; bits 31:24 have no effect on any byte sent.
- R3: The first frame holds exactly one byte, 0x06, with nothing else in that chip-select frame.
- R4: The second frame holds four bytes: 0xD8, then address bits 23:16, 15:8 and 7:0, most significant byte first.
- R5: Each status frame holds two bytes: 0x05, then a dummy 0x00. The byte received with the dummy is the status. Only its bit 0 (write in progress) steers the sequence; the other bits, including bit 1 (write-enable latch), are ignored.
- R6: Status frames repeat while bit 0 reads 1. When bit 0 reads 0, done pulses for one cycle, and busy falls in that same cycle.
- R7: Between two frames of one erase, chip select stays low for at least GAP_CYCLES cycles. Byte requests appear only while chip select is high. A requested byte holds steady until it is acknowledged, and chip select falls only after the acknowledge of the last byte of a frame.
- R8: A status frame that reads bit 0 = 1 after at least TMO_CYCLES busy cycles since start ends the erase with a one-cycle timeout pulse and no done pulse. A timeout never occurs earlier than TMO_CYCLES cycles after start.
- R9: A start pulse while busy is ignored. It changes neither the bytes sent nor the number of completion pulses.
- R10: The timeout count restarts at every accepted start, so an erase that follows a timed-out erase completes normally.
- R11: Done and timeout are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, one sector erase |
| addr_i | input | 32 | Sector address; bits 31:24 ignored |
| busy_o | output | 1 | Erase sequence in progress |
| done_o | output | 1 | One-cycle pulse: erase finished |
| timeout_o | output | 1 | One-cycle pulse: status polling exceeded the budget |
| spi_cs_o | output | 1 | Chip-select frame, high while a frame is open |
| xfer_req_o | output | 1 | Byte exchange request to the SPI master |
| xfer_byte_o | output | 8 | Byte to send |
| xfer_ack_i | input | 1 | One-cycle acknowledge: byte exchanged |
| xfer_rx_i | input | 8 | Byte received during the acknowledged exchange |

## Verification
The hardest case to reach is the timeout. It happens only when the flash stays busy across many poll frames until the busy-cycle budget is used up. The bench models the flash side of the SPI master and can hold the write-in-progress bit at 1 without limit. In that mode its scoreboard accepts an open-ended run of status frames. It then checks that the timeout pulse arrives no earlier than the budget and that done never appears. A second start pulse is injected in the middle of a sequence, and status bytes with every other bit set are returned. Together these show that neither a second start nor the other status bits change the byte stream.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam logic [7:0] OP_WR_ENABLE = 8'h06;
  localparam logic [7:0] OP_SECT_ERASE = 8'hD8;
  localparam logic [7:0] OP_RD_STATUS = 8'h05;
  localparam logic [7:0] FILL_BYTE = 8'h00;
  localparam int WIP_POS = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WEN,
    ST_GAP_WEN,
    ST_ERASE,
    ST_GAP_ERASE,
    ST_POLL,
    ST_GAP_POLL
  } sfe_state_e;
endpackage

// File: rtl/sfe_gap_timer.sv
module sfe_gap_timer #(
  parameter int GAP_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(GAP_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired_o = run_i && (cnt_q == CW'(GAP_CYCLES - 1));

  always_comb begin
    cnt_en = run_i || (cnt_q != '0);
    cnt_d  = run_i ? cnt_q + 1'b1 : '0;
    if (expired_o) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sfe_tmo_counter.sv
module sfe_tmo_counter #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic count_i,
  output logic hit_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign hit_o = (cnt_q == CW'(LIMIT));

  always_comb begin
    cnt_en = clear_i || (count_i && !hit_o);
    cnt_d  = clear_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sfe_byte_sel.sv
module sfe_byte_sel
  import sfe_pkg::*;
(
  input  sfe_state_e  state_i,
  input  logic [1:0]  idx_i,
  input  logic [23:0] offset_i,
  output logic [7:0]  byte_o,
  output logic        last_o
);
  always_comb begin
    byte_o = FILL_BYTE;
    last_o = 1'b0;
    unique case (state_i)
      ST_WEN: begin
        byte_o = OP_WR_ENABLE;
        last_o = 1'b1;
      end
      ST_ERASE: begin
        last_o = (idx_i == 2'd3);
        unique case (idx_i)
          2'd0: byte_o = OP_SECT_ERASE;
          2'd1: byte_o = offset_i[23:16];
          2'd2: byte_o = offset_i[15:8];
          default: byte_o = offset_i[7:0];
        endcase
      end
      ST_POLL: begin
        last_o = (idx_i == 2'd1);
        byte_o = (idx_i == 2'd0) ? OP_RD_STATUS : FILL_BYTE;
      end
      default: begin
        byte_o = FILL_BYTE;
        last_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/spi_flash_sector_eraser.sv
module spi_flash_sector_eraser
  import sfe_pkg::*;
#(
  parameter int GAP_CYCLES = 2,
  parameter int TMO_CYCLES = 100000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [31:0] addr_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        timeout_o,
  output logic        spi_cs_o,
  output logic        xfer_req_o,
  output logic [7:0]  xfer_byte_o,
  input  logic        xfer_ack_i,
  input  logic [7:0]  xfer_rx_i
);
  sfe_state_e  state_q, state_d;
  logic [1:0]  idx_q, idx_d;
  logic [23:0] offset_q;
  logic        done_q, done_d, tmo_q, tmo_d;
  logic        accept, in_frame, in_gap, gap_done, tmo_hit, last_byte, idx_en;

  assign accept   = start_i && (state_q == ST_IDLE);
  assign in_frame = (state_q == ST_WEN) || (state_q == ST_ERASE) || (state_q == ST_POLL);
  assign in_gap   = (state_q == ST_GAP_WEN) || (state_q == ST_GAP_ERASE) ||
                    (state_q == ST_GAP_POLL);

  sfe_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk(clk), .rst_n(rst_n), .run_i(in_gap), .expired_o(gap_done)
  );

  sfe_tmo_counter #(.LIMIT(TMO_CYCLES)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clear_i(accept),
    .count_i(state_q != ST_IDLE), .hit_o(tmo_hit)
  );

  sfe_byte_sel u_sel (
    .state_i(state_q), .idx_i(idx_q), .offset_i(offset_q),
    .byte_o(xfer_byte_o), .last_o(last_byte)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    done_d  = 1'b0;
    tmo_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_WEN;
        idx_d   = '0;
        idx_en  = 1'b1;
      end
      ST_WEN, ST_ERASE, ST_POLL: if (xfer_ack_i) begin
        idx_en = 1'b1;
        if (!last_byte) begin
          idx_d = idx_q + 1'b1;
        end else begin
          idx_d = '0;
          if (state_q == ST_WEN) state_d = ST_GAP_WEN;
          else if (state_q == ST_ERASE) state_d = ST_GAP_ERASE;
          else if (!xfer_rx_i[WIP_POS]) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else if (tmo_hit) begin
            state_d = ST_IDLE;
            tmo_d   = 1'b1;
          end else begin
            state_d = ST_GAP_POLL;
          end
        end
      end
      ST_GAP_WEN: if (gap_done) state_d = ST_ERASE;
      ST_GAP_ERASE, ST_GAP_POLL: if (gap_done) state_d = ST_POLL;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      tmo_q   <= tmo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) offset_q <= '0;
    else if (accept) offset_q <= addr_i[23:0];
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign timeout_o  = tmo_q;
  assign spi_cs_o   = in_frame;
  assign xfer_req_o = in_frame;
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       timeout_o,
  input logic       spi_cs_o,
  input logic       xfer_req_o,
  input logic [7:0] xfer_byte_o,
  input logic       xfer_ack_i
);
  assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_busy_ends_with_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_o || timeout_o));

  assert_req_inside_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req_o |-> spi_cs_o);

  assert_byte_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req_o && !xfer_ack_i) |=> $stable(xfer_byte_o));

  assert_cs_falls_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_o) |-> $past(xfer_ack_i));

  assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_o) |=> !spi_cs_o);

  assert_timeout_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  assert_results_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_o));
endmodule

bind spi_flash_sector_eraser sfe_checker u_sfe_checker (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .timeout_o(timeout_o), .spi_cs_o(spi_cs_o),
  .xfer_req_o(xfer_req_o), .xfer_byte_o(xfer_byte_o), .xfer_ack_i(xfer_ack_i)
);

// File: tb/spi_flash_sector_eraser_tb.sv
module spi_flash_sector_eraser_tb;
  localparam int GAP = 3;
  localparam int TMO = 400;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic busy_o, done_o, timeout_o, spi_cs_o, xfer_req_o;
  logic [7:0] xfer_byte_o;
  logic xfer_ack_i = 1'b0;
  logic [7:0] xfer_rx_i = '0;

  always #2 clk = ~clk;

  spi_flash_sector_eraser #(.GAP_CYCLES(GAP), .TMO_CYCLES(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o),
    .spi_cs_o(spi_cs_o), .xfer_req_o(xfer_req_o), .xfer_byte_o(xfer_byte_o),
    .xfer_ack_i(xfer_ack_i), .xfer_rx_i(xfer_rx_i)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [8:0] expq[$];
  bit endless = 0;
  int busy_polls = 0;
  logic [7:0] busy_val = 8'h03;
  logic [7:0] ready_val = 8'h02;
  int done_cnt = 0;
  int tmo_cnt = 0;
  int last_result_cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) cyc++;

  // Flash-side model of the SPI master plus scoreboard comparison of sent bytes
  initial begin
    int wait_cnt = 0;
    bit new_frame = 1;
    bit prev_rdsr = 0;
    bit endless_first = 1;
    forever begin
      @(negedge clk);
      if (!spi_cs_o) new_frame = 1;
      if (xfer_ack_i) begin
        xfer_ack_i = 1'b0;
      end else if (xfer_req_o) begin
        wait_cnt++;
        if (wait_cnt >= LAT) begin
          logic [8:0] e;
          wait_cnt = 0;
          if (expq.size() > 0) e = expq.pop_front();
          else if (endless) begin
            e = endless_first ? {1'b1, 8'h05} : {1'b0, 8'h00};
            endless_first = !endless_first;
          end else e = 9'h1FF;
          chk({new_frame, xfer_byte_o} == e, "R3/R4/R5 byte stream",
              {23'd0, new_frame, xfer_byte_o}, {23'd0, e});
          if (prev_rdsr && !new_frame) begin
            if (busy_polls > 0) begin
              xfer_rx_i = busy_val;
              busy_polls--;
            end else xfer_rx_i = ready_val;
          end else xfer_rx_i = 8'hA5;
          prev_rdsr = new_frame && (xfer_byte_o == 8'h05);
          new_frame = 0;
          xfer_ack_i = 1'b1;
        end
      end
    end
  end

  // Monitor: result pulses and chip-select gaps
  initial begin
    int low_run = 0;
    bit seen_high = 0;
    bit prev_done = 0;
    bit prev_tmo = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        seen_high = 0;
        low_run = 0;
      end else begin
        if (done_o) begin
          done_cnt++;
          last_result_cyc = cyc;
        end
        if (timeout_o) begin
          tmo_cnt++;
          last_result_cyc = cyc;
        end
        if (prev_done && done_o) chk(0, "R6 done width", 2, 1);
        if (prev_tmo && timeout_o) chk(0, "R8 timeout width", 2, 1);
        if (done_o && timeout_o) chk(0, "R11 exclusive", 1, 0);
        if (spi_cs_o) begin
          if (seen_high && low_run > 0)
            chk(low_run >= GAP, "R7 cs gap", low_run, GAP);
          seen_high = 1;
          low_run = 0;
        end else begin
          low_run++;
          if (!busy_o) seen_high = 0;
        end
        prev_done = done_o;
        prev_tmo = timeout_o;
      end
    end
  end

  task automatic push_frames(input logic [31:0] a, input int polls);
    expq.push_back({1'b1, 8'h06});
    expq.push_back({1'b1, 8'hD8});
    expq.push_back({1'b0, a[23:16]});
    expq.push_back({1'b0, a[15:8]});
    expq.push_back({1'b0, a[7:0]});
    for (int i = 0; i <= polls; i++) begin
      expq.push_back({1'b1, 8'h05});
      expq.push_back({1'b0, 8'h00});
    end
  endtask

  task automatic do_erase(input logic [31:0] a, input int polls, input logic [7:0] rdy,
                          input bit restart_mid, input bit forever_busy);
    int d0 = done_cnt;
    int t0 = tmo_cnt;
    int start_cyc;
    int guard = 0;
    busy_polls = forever_busy ? 32'h7fffffff : polls;
    ready_val = rdy;
    endless = forever_busy;
    if (forever_busy) begin
      expq.push_back({1'b1, 8'h06});
      expq.push_back({1'b1, 8'hD8});
      expq.push_back({1'b0, a[23:16]});
      expq.push_back({1'b0, a[15:8]});
      expq.push_back({1'b0, a[7:0]});
    end else push_frames(a, polls);
    @(negedge clk);
    addr_i = a;
    start_i = 1'b1;
    start_cyc = cyc;
    @(negedge clk);
    start_i = 1'b0;
    addr_i = 32'hDEAD_BEEF;
    chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    if (restart_mid) begin
      repeat (12) @(negedge clk);
      addr_i = 32'h0077_6655;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (done_cnt == d0 && tmo_cnt == t0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    if (forever_busy) begin
      chk(tmo_cnt == t0 + 1, "R8 timeout pulse", tmo_cnt - t0, 1);
      chk(done_cnt == d0, "R8 no done on timeout", done_cnt - d0, 0);
      chk(last_result_cyc - start_cyc >= TMO, "R8 not early",
          last_result_cyc - start_cyc, TMO);
      chk(busy_o == 1'b0, "R8 idle after timeout", busy_o, 0);
    end else begin
      chk(done_cnt == d0 + 1, "R6 done pulse", done_cnt - d0, 1);
      chk(tmo_cnt == t0, "R6 no timeout", tmo_cnt - t0, 0);
      chk(busy_o == 1'b0, "R6 busy low with done", busy_o, 0);
      chk(expq.size() == 0, "R5 all polls issued", expq.size(), 0);
    end
    endless = 0;
    repeat (30) @(negedge clk);
    chk(done_cnt == d0 + (forever_busy ? 0 : 1), "R9 no extra done", done_cnt - d0,
        forever_busy ? 0 : 1);
    chk(busy_o == 1'b0 && spi_cs_o == 1'b0, "R9 stays idle", {busy_o, spi_cs_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, timeout_o, spi_cs_o, xfer_req_o} == 5'b0, "R1 reset state",
        {busy_o, done_o, timeout_o, spi_cs_o, xfer_req_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy_o, spi_cs_o, xfer_req_o} == 3'b0, "R1 idle after release",
        {busy_o, spi_cs_o, xfer_req_o}, 0);
    // R2 R3 R4 R5: ready at first poll, top byte must be dropped
    do_erase(32'hAB12_3456, 0, 8'h02, 0, 0);
    // R6: several busy polls before clearing
    do_erase(32'h00FF_FFFF, 3, 8'h02, 0, 0);
    // R5: status with all other bits set, bit 0 clear
    do_erase(32'h7F00_0100, 1, 8'hFE, 0, 0);
    // R9: second start in the middle of the sequence
    do_erase(32'h0012_0000, 2, 8'h00, 1, 0);
    // R8: flash never ready
    do_erase(32'h0001_0000, 0, 8'h02, 0, 1);
    // R10: counter restarts, next erase completes
    do_erase(32'h0003_0000, 4, 8'h02, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    chk(0, "watchdog", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule